// File: doc/BRIEF.md
# Cascadable Bidirectional LCD Segment Driver Core

This block is the digital core of an 80-output dot-matrix LCD segment driver. Serial display data enters through one of two end pins of each of two 40-stage shift registers. Each register advances by one stage on every falling edge of an external shift clock. A static select input per half picks which end pin is the input and which is the output. Data can therefore run either way through each half, and the halves can be chained to each other and to further devices of the same kind.

While an external latch control is high, the 80 shift-register bits are copied into a display latch. While it is low, the latch holds and the segment outputs stay fixed. Every latched bit is combined with a frame-alternation input to form a 2-bit drive-level code. The analog switch that follows uses that code to pick one of four LCD supply rails.

The block runs on a single system clock. The shift clock and the latch control are oversampled through a two-flop synchroniser. The bidirectional end pins are split into an input, an output and an output enable each.

Top module: `lcd_seg_drv`

## Requirements
- R1: While reset is asserted, and after it is released, all shift-register stages and all latched bits are 0. Each segment code therefore reads {0, alt_i}.
- R2: The shift registers move only when a falling edge of `shift_clk_i` is detected. A high level, a low level or a rising edge leaves every stage unchanged.
- R3: With `dir_a_i`=0, the first half (stages 1..40, stage k in bit k-1) takes `a_left_in` into stage 1 and moves stage k to stage k+1. `a_right_out` presents stage 40.
- R4: With `dir_a_i`=1, the first half takes `a_right_in` into stage 40 and moves stage k to stage k-1. `a_left_out` presents stage 1.
- R5: The second half (stages 41..80) follows R3/R4 with `dir_b_i`, `b_left_*` and `b_right_*`. `b_left_out` presents stage 41 when `dir_b_i`=1.
- R6: In each pin pair exactly one output enable is high: the right pin's when its select is 0, the left pin's when it is 1. An output whose enable is low reads 0.
- R7: With both selects 0 and `a_right_out` fed to `b_left_in`, the halves form one 80-stage chain running forward. With both selects 1 and `b_left_out` fed to `a_right_in`, the chain runs in reverse.
- R8: While `latch_i` is high, the display latch follows the shift registers. While it is low, the latch and the segment codes hold even when new data is shifted in.
- R9: Segment k+1 (k=0..79) drives `level_o[2k+1:2k]` = {latched bit, alt_i}. The codes are 00 = second rail (bit 0, alt 0), 01 = third rail (bit 0, alt 1), 10 = positive supply (bit 1, alt 0) and 11 = negative supply (bit 1, alt 1).
- R10: With `dir_b_i`=0, `b_right_out` presents stage 80 so that a further device can be cascaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_clk_i | input | 1 | Serial shift clock, falling edge active |
| latch_i | input | 1 | Display latch control, level sensitive |
| alt_i | input | 1 | Frame alternation signal |
| dir_a_i | input | 1 | Shift direction select of the first half |
| dir_b_i | input | 1 | Shift direction select of the second half |
| a_left_in | input | 1 | First half left pin, input side |
| a_left_out | output | 1 | First half left pin, output side |
| a_left_oe | output | 1 | First half left pin, output enable |
| a_right_in | input | 1 | First half right pin, input side |
| a_right_out | output | 1 | First half right pin, output side |
| a_right_oe | output | 1 | First half right pin, output enable |
| b_left_in | input | 1 | Second half left pin, input side |
| b_left_out | output | 1 | Second half left pin, output side |
| b_left_oe | output | 1 | Second half left pin, output enable |
| b_right_in | input | 1 | Second half right pin, input side |
| b_right_out | output | 1 | Second half right pin, output side |
| b_right_oe | output | 1 | Second half right pin, output enable |
| level_o | output | 160 | Packed 2-bit drive-level code per segment |

## Verification
The bench builds the block with its defaults: 40 stages per half and a two-flop synchroniser. With these values a full 80-bit load through both cascade directions fits in a few thousand clocks. Running the true length makes the far-end taps (stages 1, 40, 41 and 80) and their direction-dependent roles directly observable at the pins. The two-flop depth fixes the edge-to-shift latency that the bench's pulse widths are sized around.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  typedef enum logic [1:0] {
    LVL_RAIL2 = 2'b00,
    LVL_RAIL3 = 2'b01,
    LVL_VPOS  = 2'b10,
    LVL_VNEG  = 2'b11
  } drive_lvl_e;

  function automatic drive_lvl_e lvl_encode(input logic dat, input logic alt);
    drive_lvl_e r;
    case ({dat, alt})
      2'b00:   r = LVL_RAIL2;
      2'b01:   r = LVL_RAIL3;
      2'b10:   r = LVL_VPOS;
      default: r = LVL_VNEG;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcd_seg_rstsync.sv
module lcd_seg_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/lcd_seg_sync.sv
module lcd_seg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_d[g];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcd_seg_half.sv
module lcd_seg_half #(
  parameter int LEN = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           dir,
  input  logic           left_in,
  input  logic           right_in,
  output logic           left_out,
  output logic           left_oe,
  output logic           right_out,
  output logic           right_oe,
  output logic [LEN-1:0] stages_o
);
  logic [LEN-1:0] stg_q, stg_d;

  // bit 0 is the stage nearest the left pin
  always_comb begin
    stg_d = stg_q;
    if (shift_en) begin
      if (!dir) stg_d = {stg_q[LEN-2:0], left_in};
      else      stg_d = {right_in, stg_q[LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign left_oe   = dir;
  assign right_oe  = ~dir;
  assign left_out  = dir & stg_q[0];
  assign right_out = ~dir & stg_q[LEN-1];
  assign stages_o  = stg_q;
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch
  import lcd_seg_pkg::*;
#(
  parameter int NSEG = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [NSEG-1:0]   bits_i,
  input  logic              alt_i,
  output logic [NSEG-1:0]   lat_o,
  output logic [2*NSEG-1:0] level_o
);
  logic [NSEG-1:0] lat_q, lat_d;

  always_comb lat_d = load_i ? bits_i : lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  genvar k;
  generate
    for (k = 0; k < NSEG; k++) begin : g_seg
      assign level_o[2*k +: 2] = lvl_encode(lat_q[k], alt_i);
    end
  endgenerate

  assign lat_o = lat_q;
endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv #(
  parameter int HALF_LEN    = 40,
  parameter int SYNC_STAGES = 2,
  localparam int NSEG       = 2 * HALF_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_clk_i,
  input  logic              latch_i,
  input  logic              alt_i,
  input  logic              dir_a_i,
  input  logic              dir_b_i,
  input  logic              a_left_in,
  output logic              a_left_out,
  output logic              a_left_oe,
  input  logic              a_right_in,
  output logic              a_right_out,
  output logic              a_right_oe,
  input  logic              b_left_in,
  output logic              b_left_out,
  output logic              b_left_oe,
  input  logic              b_right_in,
  output logic              b_right_out,
  output logic              b_right_oe,
  output logic [2*NSEG-1:0] level_o
);
  logic rst_sync_n;

  lcd_seg_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sync_n)
  );

  logic [1:0] ctl_raw, ctl_s;
  assign ctl_raw = {latch_i, shift_clk_i};

  lcd_seg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  logic shclk_prev_q, shclk_prev_d;
  always_comb shclk_prev_d = ctl_s[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) shclk_prev_q <= 1'b0;
    else             shclk_prev_q <= shclk_prev_d;
  end

  logic shift_fire, latch_on;
  assign shift_fire = shclk_prev_q & ~ctl_s[0];
  assign latch_on   = ctl_s[1];

  logic [1:0] dir_v, lin_v, rin_v, lout_v, loe_v, rout_v, roe_v;
  logic [NSEG-1:0] stg_all, lat_bits;

  assign dir_v = {dir_b_i, dir_a_i};
  assign lin_v = {b_left_in, a_left_in};
  assign rin_v = {b_right_in, a_right_in};

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_half
      lcd_seg_half #(.LEN(HALF_LEN)) u_half (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .shift_en (shift_fire),
        .dir      (dir_v[g]),
        .left_in  (lin_v[g]),
        .right_in (rin_v[g]),
        .left_out (lout_v[g]),
        .left_oe  (loe_v[g]),
        .right_out(rout_v[g]),
        .right_oe (roe_v[g]),
        .stages_o (stg_all[g*HALF_LEN +: HALF_LEN])
      );
    end
  endgenerate

  assign a_left_out  = lout_v[0];
  assign a_left_oe   = loe_v[0];
  assign a_right_out = rout_v[0];
  assign a_right_oe  = roe_v[0];
  assign b_left_out  = lout_v[1];
  assign b_left_oe   = loe_v[1];
  assign b_right_out = rout_v[1];
  assign b_right_oe  = roe_v[1];

  lcd_seg_latch #(.NSEG(NSEG)) u_lat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load_i (latch_on),
    .bits_i (stg_all),
    .alt_i  (alt_i),
    .lat_o  (lat_bits),
    .level_o(level_o)
  );
endmodule

// File: rtl/lcd_seg_chk.sv
module lcd_seg_chk #(
  parameter int HALF_LEN = 40,
  localparam int NSEG    = 2 * HALF_LEN
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            shift_fire,
  input logic            latch_on,
  input logic            dir_a,
  input logic            dir_b,
  input logic            a_left_in,
  input logic            a_right_in,
  input logic            b_left_in,
  input logic            b_right_in,
  input logic            a_left_oe,
  input logic            a_right_oe,
  input logic            b_left_oe,
  input logic            b_right_oe,
  input logic            b_right_out,
  input logic [NSEG-1:0] stg_all,
  input logic [NSEG-1:0] lat_bits
);
  AST_NO_SHIFT_WITHOUT_FALL: assert property (@(posedge clk) disable iff (!rst_ok)
    !shift_fire |=> $stable(stg_all)); // R2
  AST_A_FWD_SHIFT: assert property (@(posedge clk) disable iff (!rst_ok)
    (shift_fire && !dir_a) |=> (stg_all[0] == $past(a_left_in)) &&
      (stg_all[HALF_LEN-1:1] == $past(stg_all[HALF_LEN-2:0]))); // R3
  AST_A_REV_SHIFT: assert property (@(posedge clk) disable iff (!rst_ok)
    (shift_fire && dir_a) |=> (stg_all[HALF_LEN-1] == $past(a_right_in)) &&
      (stg_all[HALF_LEN-2:0] == $past(stg_all[HALF_LEN-1:1]))); // R4
  AST_B_FWD_SHIFT: assert property (@(posedge clk) disable iff (!rst_ok)
    (shift_fire && !dir_b) |=> (stg_all[HALF_LEN] == $past(b_left_in)) &&
      (stg_all[NSEG-1:HALF_LEN+1] == $past(stg_all[NSEG-2:HALF_LEN]))); // R5
  AST_B_REV_SHIFT: assert property (@(posedge clk) disable iff (!rst_ok)
    (shift_fire && dir_b) |=> (stg_all[NSEG-1] == $past(b_right_in)) &&
      (stg_all[NSEG-2:HALF_LEN] == $past(stg_all[NSEG-1:HALF_LEN+1]))); // R5
  AST_ONE_DRIVER_PER_PAIR: assert property (@(posedge clk) disable iff (!rst_ok)
    $countones({a_left_oe, a_right_oe}) == 1 && $countones({b_left_oe, b_right_oe}) == 1); // R6
  AST_LATCH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok)
    latch_on |=> lat_bits == $past(stg_all)); // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_ok)
    !latch_on |=> $stable(lat_bits)); // R8
  AST_CASCADE_TAP: assert property (@(posedge clk) disable iff (!rst_ok)
    !dir_b |-> b_right_out == stg_all[NSEG-1]); // R10
endmodule

bind lcd_seg_drv lcd_seg_chk #(.HALF_LEN(HALF_LEN)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .shift_fire (shift_fire),
  .latch_on   (latch_on),
  .dir_a      (dir_a_i),
  .dir_b      (dir_b_i),
  .a_left_in  (a_left_in),
  .a_right_in (a_right_in),
  .b_left_in  (b_left_in),
  .b_right_in (b_right_in),
  .a_left_oe  (a_left_oe),
  .a_right_oe (a_right_oe),
  .b_left_oe  (b_left_oe),
  .b_right_oe (b_right_oe),
  .b_right_out(b_right_out),
  .stg_all    (stg_all),
  .lat_bits   (lat_bits)
);

// File: tb/lcd_seg_drv_tb.sv
module lcd_seg_drv_tb;
  localparam int HL   = 40;
  localparam int NSEG = 2 * HL;
  localparam int W    = 2 * NSEG;

  typedef struct packed {
    logic        dir_a;
    logic        dir_b;
    logic        casc;
    logic        alt;
    logic [6:0]  nsh;
    logic [31:0] pat_a;
    logic [31:0] pat_b;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 7'd40, 32'hA5A5_0F0F, 32'h3C3C_9669},
    '{1'b1, 1'b0, 1'b0, 1'b1, 7'd17, 32'h1234_5678, 32'hFEDC_BA98},
    '{1'b0, 1'b1, 1'b0, 1'b0, 7'd40, 32'hFFFF_0001, 32'h8000_FFFE},
    '{1'b1, 1'b1, 1'b0, 1'b1, 7'd5,  32'h0000_0015, 32'h0000_000A},
    '{1'b0, 1'b0, 1'b1, 1'b1, 7'd80, 32'hC0FF_EE11, 32'h0000_0000},
    '{1'b1, 1'b1, 1'b1, 1'b0, 7'd80, 32'h0000_0000, 32'hDEAD_BEEF},
    '{1'b0, 1'b0, 1'b1, 1'b0, 7'd23, 32'h7777_1111, 32'h0000_0000},
    '{1'b1, 1'b0, 1'b0, 1'b1, 7'd40, 32'h5555_AAAA, 32'h0F1E_2D3C}
  };

  logic clk = 1'b0;
  logic rst_n, cl2, cl1, alt, dir_a, dir_b, casc, da, db;
  logic a_left_in, a_left_out, a_left_oe, a_right_in, a_right_out, a_right_oe;
  logic b_left_in, b_left_out, b_left_oe, b_right_in, b_right_out, b_right_oe;
  logic [W-1:0] level_o;

  always #10 clk = ~clk;

  assign a_left_in  = da;
  assign a_right_in = (casc && dir_a) ? b_left_out : da;
  assign b_left_in  = (casc && !dir_b) ? a_right_out : db;
  assign b_right_in = db;

  lcd_seg_drv u_dut (
    .clk(clk), .rst_n(rst_n), .shift_clk_i(cl2), .latch_i(cl1), .alt_i(alt),
    .dir_a_i(dir_a), .dir_b_i(dir_b),
    .a_left_in(a_left_in), .a_left_out(a_left_out), .a_left_oe(a_left_oe),
    .a_right_in(a_right_in), .a_right_out(a_right_out), .a_right_oe(a_right_oe),
    .b_left_in(b_left_in), .b_left_out(b_left_out), .b_left_oe(b_left_oe),
    .b_right_in(b_right_in), .b_right_out(b_right_out), .b_right_oe(b_right_oe),
    .level_o(level_o)
  );

  logic [NSEG-1:0] mdl, lat_mdl;
  int checks = 0;
  int fails  = 0;

  function automatic logic [W-1:0] exp_lvl(input logic [NSEG-1:0] bits, input logic m);
    logic [W-1:0] r;
    for (int k = 0; k < NSEG; k++) r[2*k +: 2] = {bits[k], m};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step_model();
    logic [NSEG-1:0] old;
    logic in_a, in_b;
    old  = mdl;
    in_a = (casc && dir_a) ? old[HL] : da;
    in_b = (casc && !dir_b) ? old[HL-1] : db;
    if (!dir_a) mdl[HL-1:0] = {old[HL-2:0], in_a};
    else        mdl[HL-1:0] = {in_a, old[HL-1:1]};
    if (!dir_b) mdl[NSEG-1:HL] = {old[NSEG-2:HL], in_b};
    else        mdl[NSEG-1:HL] = {in_b, old[NSEG-1:HL+1]};
  endtask

  task automatic pulse();
    cl2 = 1'b1;
    repeat (4) @(negedge clk);
    cl2 = 1'b0;
    repeat (4) @(negedge clk);
    step_model();
  endtask

  task automatic do_latch();
    cl1 = 1'b1;
    repeat (5) @(negedge clk);
    cl1 = 1'b0;
    repeat (5) @(negedge clk);
    lat_mdl = mdl;
  endtask

  task automatic pin_check(input string tag);
    logic [W-1:0] act, exp;
    act = '0;
    exp = '0;
    act[7:0] = {a_left_oe, a_right_oe, b_left_oe, b_right_oe,
                a_left_out, a_right_out, b_left_out, b_right_out};
    exp[7:0] = {dir_a, !dir_a, dir_b, !dir_b,
                dir_a ? mdl[0] : 1'b0, dir_a ? 1'b0 : mdl[HL-1],
                dir_b ? mdl[HL] : 1'b0, dir_b ? 1'b0 : mdl[NSEG-1]};
    chk(tag, act, exp);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cl2 = 1'b0; cl1 = 1'b0; alt = 1'b0;
    dir_a = 1'b0; dir_b = 1'b0; casc = 1'b0; da = 1'b0; db = 1'b0;
    mdl = '0; lat_mdl = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 codes during reset", level_o, exp_lvl('0, 1'b0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 codes after reset alt=0", level_o, exp_lvl('0, 1'b0));
    alt = 1'b1;
    #1;
    chk("R1 R9 codes after reset alt=1", level_o, exp_lvl('0, 1'b1));
    pin_check("R1 R6 pins after reset");

    // table walk
    for (int v = 0; v < 8; v++) begin
      dir_a = VECS[v].dir_a;
      dir_b = VECS[v].dir_b;
      casc  = VECS[v].casc;
      alt   = VECS[v].alt;
      repeat (2) @(negedge clk);
      for (int j = 0; j < int'(VECS[v].nsh); j++) begin
        da = VECS[v].pat_a[j % 32];
        db = VECS[v].pat_b[j % 32];
        pulse();
      end
      chk($sformatf("R8 hold while latch low, vector %0d", v), level_o, exp_lvl(lat_mdl, alt));
      pin_check($sformatf("R3/R4/R5/R6/R10 pins, vector %0d", v));
      do_latch();
      chk($sformatf("R3/R4/R5/R7/R9 codes, vector %0d", v), level_o, exp_lvl(lat_mdl, alt));
    end

    // alternation flip on held data
    alt = ~alt;
    #1;
    chk("R9 codes after alt flip", level_o, exp_lvl(lat_mdl, alt));

    // rising edge alone must not shift
    dir_a = 1'b0; dir_b = 1'b0; casc = 1'b0;
    da = ~mdl[0]; db = ~mdl[HL];
    cl2 = 1'b1;
    repeat (8) @(negedge clk);
    do_latch();
    chk("R2 no shift on rising edge or high level", level_o, exp_lvl(lat_mdl, alt));
    cl2 = 1'b0;
    repeat (4) @(negedge clk);
    step_model();
    do_latch();
    chk("R2 shift on falling edge", level_o, exp_lvl(lat_mdl, alt));

    // mid-run reset
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 latch cleared by reset", level_o, exp_lvl('0, alt));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl = '0;
    do_latch();
    chk("R1 shift stages cleared by reset", level_o, exp_lvl('0, alt));
    pin_check("R1 R6 R10 pins after second reset");

    summary();
    $finish;
  end
endmodule